// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that a processor core reads and writes over a small register bus. Each count step comes from one of two sources. The first is the core's instruction-cycle tick. The second is an edge on an external input pin, which is passed through a synchronizer first. A single power-of-two divider sits in front of one consumer at a time. That consumer is either the counter or a watchdog divider chain outside this block. A control field picks the owner, and the owner decides both the ratio table and the event that clears the divider.

When the counter wraps from its maximum value back to zero, it raises a sticky overflow flag, and software clears the flag through the bus. The divided tick toward the watchdog leaves on its own output pin. The watchdog's timeout logic is not part of this block. After software loads the counter, counting pauses for two instruction cycles, which stands in for the pipeline delay of the synchronizer.

Top module: `tmr_core`

## Requirements
- R1: After reset, the control register reads 0x3F, the counter reads 0, the overflow flag is 0 and `wdog_tick` is low.
- R2: The bus addresses are 0 for the counter, 1 for control and 2 for the flag (bit 0), and address 3 reads as 0. In the control register, bits [2:0] hold the ratio code, bit 3 the owner (1 = watchdog), bit 4 the edge (1 = falling) and bit 5 the source (1 = external pin), and bits 7:6 read as 0. Read data appears on the cycle after the address.
- R3: When the counter owns the divider, it advances once per 2^(code+1) accepted source ticks, counted from the last divider clear.
- R4: When the watchdog owns the divider, the counter advances on every accepted source tick. In that mode `wdog_tick` pulses once per 2^code `wdog_base_tick` pulses, one cycle after the pulse that completes each group.
- R5: When the counter owns the divider, `wdog_tick` repeats `wdog_base_tick` one cycle later, and `wdog_clr` has no effect on the divider.
- R6: A bus write to the counter loads the written value. If the counter owns the divider, the write also clears the divider. The write never changes the control register.
- R7: When the watchdog owns the divider, `wdog_clr` clears the divider, so a full group of 2^code base pulses must follow before the next `wdog_tick`.
- R8: After a counter write, the next two `cyc_tick` pulses are blocked. Source ticks that arrive while the block is in force are discarded, and neither the counter nor the divider moves on them.
- R9: When the external source is selected, each rising edge (edge bit 0) or each falling edge (edge bit 1) of `ext_clk_in` gives one source tick, provided the pin holds each level for at least 2 clocks. In this mode `cyc_tick` does not advance the counter.
- R10: A step from 0xFF wraps the counter to 0x00 and sets the flag. The flag stays set until any bus write to address 2 clears it, and a wrap in the same cycle wins over that clear.
- R11: `ovf_flag` always shows the state of the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| ext_clk_in | input | 1 | Asynchronous external count input |
| wdog_base_tick | input | 1 | Base tick of the watchdog chain |
| wdog_clr | input | 1 | Watchdog-clear strobe |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdog_tick | output | 1 | Divided (or passed-through) tick toward the watchdog |

## Verification
Each result has its own latency:
- A counter step or a flag change is visible on the clock edge that takes the accepted tick.
- A read returns data one edge after the address is presented.
- `wdog_tick` follows its base pulse by one edge.
- An external edge reaches the counter on the third edge after the pin changes.

The bench drives every input on falling clock edges and samples outputs there too. Each pin level is held for three cycles before the count is read, and `wdog_tick` is sampled on every falling edge of a pulse train, so each pulse is counted exactly once. Expected counts come from functions that apply the two discarded ticks and the ratio for the current owner.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int RATE_W = 3;

  typedef struct packed {
    logic                src_ext;
    logic                edge_fall;
    logic                own_wdog;
    logic [RATE_W-1:0]   rate;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

  typedef enum logic [1:0] {
    ADDR_COUNT = 2'd0,
    ADDR_CTRL  = 2'd1,
    ADDR_FLAG  = 2'd2,
    ADDR_NONE  = 2'd3
  } tmr_addr_e;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  genvar gi;
  for (gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b0;
        else     chain_q[gi] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b0;
        else     chain_q[gi] <= chain_q[gi-1];
      end
    end
  end

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= synced;
  end

  assign evt = fall_sel ? (last_q & ~synced) : (synced & ~last_q);

endmodule

// File: rtl/tmr_write_guard.sv
module tmr_write_guard #(
  parameter int HOLD_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cyc_tick,
  input  logic src_in,
  output logic src_out,
  output logic busy
);

  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] left_q;

  assign busy    = (left_q != '0);
  assign src_out = src_in & ~busy;

  always_ff @(posedge clk) begin
    if (rst)                   left_q <= '0;
    else if (load)             left_q <= HW'(HOLD_TICKS);
    else if (cyc_tick && busy) left_q <= left_q - 1'b1;
  end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              own_wdog,
  input  logic [RATE_W-1:0] rate,
  input  logic              tmr_src,
  input  logic              wdog_src,
  input  logic              clr,
  output logic              tmr_tick,
  output logic              wdog_pre
);

  localparam int SPAN_W = PRE_W + 1;

  logic [PRE_W-1:0]  pcnt_q;
  logic [PRE_W-1:0]  mask;
  logic [SPAN_W-1:0] span;
  logic              in_tick;
  logic              hit;

  always_comb begin
    if (own_wdog) span = SPAN_W'(1) << rate;
    else          span = SPAN_W'(2) << rate;
    mask = PRE_W'(span - 1'b1);
  end

  assign in_tick  = own_wdog ? wdog_src : tmr_src;
  assign hit      = in_tick && !clr && ((pcnt_q & mask) == mask);
  assign tmr_tick = own_wdog ? tmr_src : hit;
  assign wdog_pre = own_wdog ? hit : wdog_src;

  always_ff @(posedge clk) begin
    if (rst || clr)   pcnt_q <= '0;
    else if (in_tick) pcnt_q <= pcnt_q + 1'b1;
  end

endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             inc,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);

  logic wrap;

  assign wrap = inc && !load && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_tick,
  input  logic             ext_clk_in,
  input  logic             wdog_base_tick,
  input  logic             wdog_clr,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             ovf_flag,
  output logic             wdog_tick
);

  tmr_ctrl_t        ctrl_q;
  logic             wr_cnt, wr_ctrl, wr_flag;
  logic             ext_evt, src_raw, src_ok, guard_busy;
  logic             pre_clr, tmr_tick, wdog_pre;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic [CNT_W-1:0] rd_next;

  assign wr_cnt  = bus_we && (tmr_addr_e'(bus_addr) == ADDR_COUNT);
  assign wr_ctrl = bus_we && (tmr_addr_e'(bus_addr) == ADDR_CTRL);
  assign wr_flag = bus_we && (tmr_addr_e'(bus_addr) == ADDR_FLAG);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '1;
    else if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin      (ext_clk_in),
    .fall_sel (ctrl_q.edge_fall),
    .evt      (ext_evt)
  );

  assign src_raw = ctrl_q.src_ext ? ext_evt : cyc_tick;

  tmr_write_guard #(.HOLD_TICKS(HOLD_TICKS)) u_guard (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_cnt),
    .cyc_tick (cyc_tick),
    .src_in   (src_raw),
    .src_out  (src_ok),
    .busy     (guard_busy)
  );

  assign pre_clr = (wr_cnt && !ctrl_q.own_wdog) || (wdog_clr && ctrl_q.own_wdog);

  tmr_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .own_wdog (ctrl_q.own_wdog),
    .rate     (ctrl_q.rate),
    .tmr_src  (src_ok),
    .wdog_src (wdog_base_tick),
    .clr      (pre_clr),
    .tmr_tick (tmr_tick),
    .wdog_pre (wdog_pre)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .inc      (tmr_tick),
    .flag_clr (wr_flag),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q)
  );

  always_comb begin
    case (tmr_addr_e'(bus_addr))
      ADDR_COUNT: rd_next = cnt_q;
      ADDR_CTRL:  rd_next = CNT_W'(ctrl_q);
      ADDR_FLAG:  rd_next = CNT_W'(flag_q);
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      wdog_tick <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      wdog_tick <= wdog_pre;
    end
  end

  assign ovf_flag = flag_q;

endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             guard_busy,
  input logic             own_wdog,
  input logic             wdog_base_tick,
  input logic             wdog_tick,
  input logic             ovf_flag
);

  logic wr_cnt_c;
  assign wr_cnt_c = bus_we && (bus_addr == 2'd0);

  AST_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_cnt_c |=> cnt_q == $past(bus_wdata)); // R6

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt_c |=> (cnt_q == $past(cnt_q)) || (cnt_q == ($past(cnt_q) + CNT_W'(1)))); // R3

  AST_HOLD_DURING_INHIBIT: assert property (@(posedge clk) disable iff (rst)
    (guard_busy && !wr_cnt_c) |=> cnt_q == $past(cnt_q)); // R8

  AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(cnt_q) == '1) && (cnt_q == '0)); // R10

  AST_WDOG_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (!own_wdog && wdog_base_tick) |=> wdog_tick); // R5

  AST_WDOG_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!own_wdog && !wdog_base_tick) |=> !wdog_tick); // R5

endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .cnt_q          (cnt_q),
  .guard_busy     (guard_busy),
  .own_wdog       (ctrl_q.own_wdog),
  .wdog_base_tick (wdog_base_tick),
  .wdog_tick      (wdog_tick),
  .ovf_flag       (ovf_flag)
);

// File: tb/tmr_core_tb.sv
`timescale 1ns/1ps
module tmr_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_tick = 1'b0;
  logic       ext_clk_in = 1'b0;
  logic       wdog_base_tick = 1'b0;
  logic       wdog_clr = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;
  logic       wdog_tick;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tmr_core dut_i (
    .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .ext_clk_in(ext_clk_in),
    .wdog_base_tick(wdog_base_tick), .wdog_clr(wdog_clr), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_flag(ovf_flag), .wdog_tick(wdog_tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_inc(input int own, input int rate, input int n);
    int acc = (n > 2) ? n - 2 : 0;
    return own ? acc : (acc >> (rate + 1));
  endfunction

  function automatic int exp_wdog(input int n, input int rate);
    return n >> rate;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = int'(bus_rdata);
  endtask

  task automatic cticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cyc_tick = 1'b1;
      @(negedge clk); cyc_tick = 1'b0;
    end
  endtask

  task automatic wbase(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (wdog_tick) seen++; wdog_base_tick = 1'b1;
      @(negedge clk); if (wdog_tick) seen++; wdog_base_tick = 1'b0;
    end
    @(negedge clk); if (wdog_tick) seen++;
  endtask

  task automatic wclr();
    @(negedge clk); wdog_clr = 1'b1;
    @(negedge clk); wdog_clr = 1'b0;
  endtask

  task automatic ext_set(input logic v);
    @(negedge clk); ext_clk_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_all();
    int v, f, seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 wdog_tick", int'(wdog_tick), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    rd(2'd1, v); chk("R1 ctrl", v, 8'h3F);
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd2, v); chk("R1 flag", v, 0);
    // R2 map and unused bits
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 ctrl upper bits", v, 8'h3F);
    rd(2'd3, v); chk("R2 addr3", v, 0);

    // R8 directed: two blocked ticks after a load
    wr(2'd1, 8'h08); wr(2'd0, 8'd10);
    cticks(2); rd(2'd0, v); chk("R8 held", v, 10);
    cticks(1); rd(2'd0, v); chk("R8 resumes", v, 11);

    // R3/R4/R10 random: internal source, both owners
    for (int it = 0; it < 24; it++) begin
      int rate  = int'($urandom % 8);
      int own   = int'($urandom % 2);
      int n     = 2 + int'($urandom % 40);
      int start = (($urandom % 4) == 0) ? 250 + int'($urandom % 6) : int'($urandom % 256);
      int inc   = exp_inc(own, rate, n);
      wr(2'd2, 8'd0);
      wr(2'd1, 8'((own << 3) | rate));
      wr(2'd0, 8'(start));
      cticks(n);
      rd(2'd0, v);
      chk(own ? "R4 count" : "R3 count", v, (start + inc) & 8'hFF);
      rd(2'd2, f);
      chk("R10 flag", f, (start + inc > 255) ? 1 : 0);
    end

    // R4 random: watchdog-owned division
    for (int it = 0; it < 6; it++) begin
      int rate = int'($urandom % 8);
      int n    = 1 + int'($urandom % 300);
      wr(2'd1, 8'(8'h08 | rate));
      wclr();
      wbase(n, seen);
      chk("R4 wdog ticks", seen, exp_wdog(n, rate));
    end

    // R7 clear restarts the group
    wr(2'd1, 8'h0B); wclr();
    wbase(5, seen); wclr();
    wbase(7, seen); chk("R7 after clear", seen, 0);
    wbase(1, seen); chk("R7 group done", seen, 1);

    // R5 passthrough, clear ignored by timer-owned divider
    wr(2'd1, 8'h02); wbase(9, seen); chk("R5 passthrough", seen, 9);
    wr(2'd1, 8'h01); wr(2'd0, 8'd0);
    cticks(4); wclr(); cticks(2);
    rd(2'd0, v); chk("R5 clear ignored", v, 1);

    // R6 load clears timer-owned divider, control unchanged
    wr(2'd1, 8'h02); wr(2'd0, 8'd0);
    cticks(7); wr(2'd0, 8'd0);
    cticks(9); rd(2'd0, v); chk("R6 divider cleared", v, 0);
    cticks(1); rd(2'd0, v); chk("R6 first step", v, 1);
    rd(2'd1, v); chk("R6 ctrl kept", v, 8'h02);

    // R9 external edges
    wr(2'd1, 8'h28); wr(2'd0, 8'd0); cticks(3);
    ext_set(1'b1); rd(2'd0, v); chk("R9 rising", v, 1);
    ext_set(1'b0); rd(2'd0, v); chk("R9 fall ignored", v, 1);
    for (int i = 0; i < 4; i++) begin ext_set(1'b1); ext_set(1'b0); end
    rd(2'd0, v); chk("R9 five rises", v, 5);
    cticks(5); rd(2'd0, v); chk("R9 cyc ignored", v, 5);
    wr(2'd1, 8'h38);
    ext_set(1'b1); rd(2'd0, v); chk("R9 rise ignored", v, 5);
    ext_set(1'b0); rd(2'd0, v); chk("R9 falling", v, 6);
    wr(2'd1, 8'h20); wr(2'd0, 8'd0); cticks(2);
    for (int i = 0; i < 4; i++) begin ext_set(1'b1); ext_set(1'b0); end
    rd(2'd0, v); chk("R9 divided", v, 2);

    // R10/R11 wrap and sticky flag
    wr(2'd1, 8'h08); wr(2'd2, 8'd0); wr(2'd0, 8'hFF);
    cticks(3);
    rd(2'd0, v); chk("R10 wrap", v, 0);
    rd(2'd2, v); chk("R10 set", v, 1);
    chk("R11 port set", int'(ovf_flag), 1);
    cticks(2); rd(2'd2, v); chk("R10 sticky", v, 1);
    wr(2'd2, 8'd0); rd(2'd2, v); chk("R10 cleared", v, 0);
    chk("R11 port clear", int'(ovf_flag), 0);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL all: watchdog actual=running expected=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule